// File: doc/BRIEF.md
# DRAM Column-Phase Wait-State Sequencer

This block steps one DRAM access through its column phase. After a start request it runs a first column state, then zero or more wait states, then a second column state. It then returns to idle. The wait states come from two sources. The first is a programmed 3-bit count, which is used only when the accessed area has its wait-enable bit set. The second is an external active-low WAIT input, which is honoured only when both a global pin-wait enable and the area's wait-enable bit are set.

When pin waiting is active, the programmed waits always run first, and at least one of them is inserted even when the count is zero. The WAIT input is captured on the falling clock edge inside the last wait state. A low sample adds one more wait state, and this repeats until a high sample is seen. The sample from each falling edge is acted on at the following rising edge.

For reads, the CAS strobe covers the first column state, every wait state and the second column state, so the waits lengthen the CAS pulse. For writes, the write data is driven from the first column state onward and CAS rises only in the second column state, so the waits lengthen the data setup time before CAS. All registers use an asynchronous active-low reset, which is assumed to be released synchronously upstream.

Top module: `dram_col_wait_seq`

## Requirements
- R1: An asynchronous low on rst_n puts the sequencer in idle (state_o = 2'b00) with cas_o, wdata_oe_o and done_o low, with no clock edge needed.
- R2: A start_i sampled high in idle moves state_o to column-1 (2'b01) at that rising edge. Column-1 lasts one cycle and is followed by zero or more wait cycles (2'b10), then exactly one column-2 cycle (2'b11).
- R3: With area_wait_en_i at 0, column-1 goes straight to column-2. Both wait_cnt_i and wait_n_i are ignored.
- R4: With area_wait_en_i at 1 and pin_wait_en_i at 0, exactly wait_cnt_i wait cycles (0 to 7) are inserted, and wait_n_i is ignored.
- R5: With both enables at 1, max(wait_cnt_i, 1) programmed wait cycles are inserted whatever the level of wait_n_i during them.
- R6: With both enables at 1, wait_n_i is sampled on the falling edge within the last wait cycle. A low sample adds one more wait cycle, and this repeats while the samples stay low. Column-2 follows the first wait cycle whose sample is high.
- R7: In a read (write_i = 0), cas_o is high in column-1, in every wait cycle and in column-2, and wdata_oe_o stays low.
- R8: In a write (write_i = 1), wdata_oe_o is high from column-1 through column-2, and cas_o is high only in column-2.
- R9: done_o is high for exactly the column-2 cycle. The next cycle is idle, and a start_i presented in that idle cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state advances on rising edges and WAIT is sampled on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a column phase, sampled in idle |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle, captured with start |
| area_wait_en_i | input | 1 | Wait enable of the accessed area, captured with start |
| pin_wait_en_i | input | 1 | Global enable for WAIT-pin extension, captured with start |
| wait_cnt_i | input | 3 | Programmed wait count, captured with start |
| wait_n_i | input | 1 | External active-low wait request |
| state_o | output | 2 | 00 idle, 01 column-1, 10 wait, 11 column-2 |
| cas_o | output | 1 | Column strobe, active high |
| wdata_oe_o | output | 1 | Write-data drive enable |
| done_o | output | 1 | High during the column-2 cycle |

## Verification
Every output is decoded from the state register, so each result is due in the cycle that begins at the rising edge that changed the state. Column-1 appears at the edge that samples start_i, and each later state appears one edge after the previous one. The bench drives inputs and samples outputs 2 ns after each rising edge, one full cycle after the previous decision. It sets wait_n_i before the falling edge of the wait cycle in which that sample is meant to count, so a low seen at that falling edge shows up as one extra wait cycle at the next sample point. The asynchronous reset is checked 1 ns after rst_n falls, with no clock edge in between.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_COL1 = 2'b01,
    ST_WAIT = 2'b10,
    ST_COL2 = 2'b11
  } dcw_state_e;
endpackage

// File: rtl/dcw_wait_sampler.sv
module dcw_wait_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en_i,
  input  logic wait_n_i,
  output logic wait_low_o
);
  logic wait_low_q;
  logic wait_low_d;

  always_comb begin
    wait_low_d = wait_low_q;
    if (sample_en_i) wait_low_d = ~wait_n_i;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) wait_low_q <= 1'b0;
    else        wait_low_q <= wait_low_d;
  end

  assign wait_low_o = wait_low_q;
endmodule

// File: rtl/dcw_wait_counter.sv
module dcw_wait_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             empty_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load_i)                          rem_d = load_val_i;
    else if (dec_i && (rem_q != '0))     rem_d = rem_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign empty_o = (rem_q == '0);
  assign last_o  = (rem_q == ONE);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && empty_o) |=> empty_o);
endmodule

// File: rtl/dcw_fsm.sv
module dcw_fsm
  import dcw_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic             area_wait_en_i,
  input  logic             pin_wait_en_i,
  input  logic [CNT_W-1:0] wait_cnt_i,
  input  logic             cnt_empty_i,
  input  logic             cnt_last_i,
  input  logic             wait_low_i,
  output dcw_state_e       state_o,
  output logic             write_o,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_load_val_o,
  output logic             cnt_dec_o,
  output logic             sample_en_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  dcw_state_e state_q, state_d;
  logic       write_q, write_d;
  logic       pin_act_q, pin_act_d;
  logic       accept;
  logic       pin_act_in;

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign pin_act_in = area_wait_en_i && pin_wait_en_i;

  always_comb begin
    cnt_load_val_o = '0;
    if (area_wait_en_i) begin
      if (pin_act_in && (wait_cnt_i == '0)) cnt_load_val_o = ONE;
      else                                  cnt_load_val_o = wait_cnt_i;
    end
  end

  always_comb begin
    state_d   = state_q;
    write_d   = write_q;
    pin_act_d = pin_act_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_COL1;
          write_d   = write_i;
          pin_act_d = pin_act_in;
        end
      end
      ST_COL1: state_d = cnt_empty_i ? ST_COL2 : ST_WAIT;
      ST_WAIT: begin
        if (!cnt_empty_i && !cnt_last_i)        state_d = ST_WAIT;
        else if (pin_act_q && wait_low_i)       state_d = ST_WAIT;
        else                                    state_d = ST_COL2;
      end
      ST_COL2: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      write_q   <= 1'b0;
      pin_act_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      write_q   <= write_d;
      pin_act_q <= pin_act_d;
    end
  end

  assign cnt_load_o  = accept;
  assign cnt_dec_o   = (state_q == ST_WAIT);
  assign sample_en_o = (state_q == ST_WAIT) || (state_q == ST_COL1);
  assign state_o     = state_q;
  assign write_o     = write_q;

  // R2
  start_to_col1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_COL1));
  // R2
  col1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COL1) |=> (state_q == ST_WAIT || state_q == ST_COL2));
  // R5
  pin_min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COL1 && pin_act_q) |=> (state_q == ST_WAIT));
  // R9
  col2_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COL2) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dcw_strobe_decode.sv
module dcw_strobe_decode
  import dcw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dcw_state_e state_i,
  input  logic       write_i,
  output logic       cas_o,
  output logic       wdata_oe_o,
  output logic       done_o
);
  logic active;

  always_comb begin
    active = (state_i != ST_IDLE);
    done_o = (state_i == ST_COL2);
    if (write_i) begin
      cas_o      = (state_i == ST_COL2);
      wdata_oe_o = active;
    end else begin
      cas_o      = active;
      wdata_oe_o = 1'b0;
    end
  end

  // R9
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  write_cas_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write_i && cas_o) |=> !cas_o && !wdata_oe_o);
endmodule

// File: rtl/dram_col_wait_seq.sv
module dram_col_wait_seq
  import dcw_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic             area_wait_en_i,
  input  logic             pin_wait_en_i,
  input  logic [CNT_W-1:0] wait_cnt_i,
  input  logic             wait_n_i,
  output logic [1:0]       state_o,
  output logic             cas_o,
  output logic             wdata_oe_o,
  output logic             done_o
);
  dcw_state_e       state;
  logic             write_q;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  logic             cnt_dec;
  logic             cnt_empty;
  logic             cnt_last;
  logic             sample_en;
  logic             wait_low;

  dcw_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .write_i        (write_i),
    .area_wait_en_i (area_wait_en_i),
    .pin_wait_en_i  (pin_wait_en_i),
    .wait_cnt_i     (wait_cnt_i),
    .cnt_empty_i    (cnt_empty),
    .cnt_last_i     (cnt_last),
    .wait_low_i     (wait_low),
    .state_o        (state),
    .write_o        (write_q),
    .cnt_load_o     (cnt_load),
    .cnt_load_val_o (cnt_load_val),
    .cnt_dec_o      (cnt_dec),
    .sample_en_o    (sample_en)
  );

  dcw_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .empty_o    (cnt_empty),
    .last_o     (cnt_last)
  );

  dcw_wait_sampler u_smp (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en_i (sample_en),
    .wait_n_i    (wait_n_i),
    .wait_low_o  (wait_low)
  );

  dcw_strobe_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state),
    .write_i    (write_q),
    .cas_o      (cas_o),
    .wdata_oe_o (wdata_oe_o),
    .done_o     (done_o)
  );

  assign state_o = state;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (state_o == 2'b00 && !cas_o && !wdata_oe_o && !done_o));
  // R7
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 && cas_o) |=> (cas_o && !wdata_oe_o));
endmodule

// File: tb/test_dram_col_wait_seq.sv
module test_dram_col_wait_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {write, area, pin, cnt[2:0], exp_waits[3:0], hold_low}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 3'd5, 4'd0, 1'b1},
    {1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 1'b1},
    {1'b0, 1'b1, 1'b0, 3'd7, 4'd7, 1'b1},
    {1'b1, 1'b1, 1'b0, 3'd3, 4'd3, 1'b1},
    {1'b0, 1'b1, 1'b1, 3'd0, 4'd1, 1'b0},
    {1'b0, 1'b1, 1'b1, 3'd0, 4'd4, 1'b0},
    {1'b1, 1'b1, 1'b1, 3'd2, 4'd2, 1'b0},
    {1'b1, 1'b1, 1'b1, 3'd2, 4'd5, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'd7, 4'd0, 1'b1},
    {1'b1, 1'b1, 1'b1, 3'd7, 4'd9, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, write_i, area_i, pin_i, wait_n_i;
  logic [2:0] cnt_i;
  logic [1:0] state_o;
  logic       cas_o, oe_o, done_o;
  int         checks = 0;
  int         fails = 0;
  bit         finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_col_wait_seq i_dram_col_wait_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .area_wait_en_i(area_i), .pin_wait_en_i(pin_i), .wait_cnt_i(cnt_i),
    .wait_n_i(wait_n_i), .state_o(state_o), .cas_o(cas_o),
    .wdata_oe_o(oe_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 0; write_i = 0; area_i = 0; pin_i = 0;
    cnt_i = 0; wait_n_i = 1;
    #3;
    chk("R1", "reset state", state_o, 0);
    chk("R1", "reset cas/oe/done", {cas_o, oe_o, done_o}, 0);
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1", "idle after release", state_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic       w, a, p, hold;
      logic [2:0] c;
      int         expw, tw;
      string      req;
      {w, a, p, c} = VEC[v][10:5];
      expw = int'(VEC[v][4:1]);
      hold = VEC[v][0];
      req = !a ? "R3" : (!p ? "R4" : (expw > ((c == 0) ? 1 : int'(c)) ? "R6" : "R5"));
      write_i = w; area_i = a; pin_i = p; cnt_i = c; start_i = 1; wait_n_i = 0;
      @(posedge clk); #2;
      start_i = 0;
      chk("R2", "column-1 after start", state_o, 1);
      chk(w ? "R8" : "R7", "col1 cas/oe", {cas_o, oe_o}, w ? 1 : 2);
      chk("R9", "no done in col1", done_o, 0);
      tw = 0;
      for (int g = 0; g < 30; g++) begin
        @(posedge clk); #2;
        if (state_o != 2'b10) break;
        tw++;
        chk(w ? "R8" : "R7", "wait cas/oe", {cas_o, oe_o}, w ? 1 : 2);
        wait_n_i = hold ? 1'b0 : ((tw < expw) ? 1'b0 : 1'b1);
      end
      chk("R2", "column-2 ends phase", state_o, 3);
      chk(req, "wait cycle count", tw, expw);
      chk("R9", "done in col2", done_o, 1);
      chk(w ? "R8" : "R7", "col2 cas/oe", {cas_o, oe_o}, w ? 3 : 2);
      wait_n_i = 1;
      @(posedge clk); #2;
      chk("R9", "idle after col2", state_o, 0);
      chk("R9", "done dropped", {done_o, cas_o, oe_o}, 0);
    end

    // Async reset in the middle of a pin-extended write
    write_i = 1; area_i = 1; pin_i = 1; cnt_i = 1; start_i = 1; wait_n_i = 0;
    @(posedge clk); #2 start_i = 0;
    @(posedge clk); #2;
    chk("R6", "wait entered", state_o, 2);
    @(posedge clk); #2;
    chk("R6", "still waiting on low pin", state_o, 2);
    rst_n = 0; #1;
    chk("R1", "async reset state", state_o, 0);
    chk("R1", "async reset outputs", {cas_o, oe_o, done_o}, 0);
    @(posedge clk); #2 rst_n = 1; wait_n_i = 1;
    @(posedge clk); #2;
    chk("R1", "stays idle after reset", state_o, 0);
    finish_run();
  end
endmodule